// File: doc/BRIEF.md
# Seconds Watchdog With Magic-Byte Kick

This block is a watchdog timer behind a four-register, byte-wide synchronous port. Once enabled, it counts whole seconds down from a programmed period. A prescaler turns the system clock into one tick per second. Software keeps the system alive by writing one specific byte value to the kick register. Any other value written there does nothing, so a stray write cannot service the watchdog.

When the count runs out, the block can drive two outputs: a system-reset request and a separate timeout indication. Each output has its own select bit, and each selected output is held high for a fixed number of clock cycles. A sticky lock bit stops software from turning the watchdog off once it has been armed. Only a hardware reset releases the lock.

A typical start sequence has three steps: program the period, set the enable and output-select bits (and optionally the lock) with one control write, then kick at regular intervals. Software reads the count register to see how many seconds are left.

Top module: `magic_kick_watchdog`

## Requirements
- R1: After reset, the registers read as follows: control 0x00, period equal to the `RESET_PERIOD` parameter (default 10), count 0x00. Both outputs are low.
- R2: The register offsets are 0 = control, 1 = period, 2 = kick, 3 = count. Read data is combinational from `bus_addr`. The kick register reads 0x00. In the control register, bit 0 is enable, bit 2 is lock, bit 6 selects the reset output and bit 7 selects the timeout output. All other control bits read 0.
- R3: The period register stores any 8-bit value written to it and reads it back unchanged.
- R4: A control write that changes enable from 0 to 1 loads the count from the period register. The count then drops by one every `TICK_CYCLES` clocks. The first drop happens `TICK_CYCLES` cycles after the write edge.
- R5: Writing 0x6B to the kick register reloads the count from the period register and restarts the second prescaler. A kick with any other value, or any kick while the block is disabled, leaves the count unchanged.
- R6: Expiry happens on the tick at which the count is 1 or less. The count goes to 0. Each selected output goes high in the cycle after that edge and stays high for exactly `PULSE_CYCLES` cycles.
- R7: If the reset output was selected, the count stays at 0 after the pulse until a kick or a fresh enable. If it was not selected, the count reloads from the period register at the edge where the pulse ends.
- R8: A period of 0 expires on the first tick after the load.
- R9: While unlocked, writing enable = 0 stops the countdown, holds the count and forces both outputs low.
- R10: The lock bit is sticky until reset. While the lock is set, a written 0 does not clear an enable that is already 1. The select bits remain writable.
- R11: A kick during an output pulse is ignored. The pulse runs to its full length and the count stays at 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_wr | input | 1 | Write strobe, one cycle per write |
| bus_addr | input | 2 | Register offset |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data for `bus_addr` |
| sys_rst_o | output | 1 | System-reset request pulse on expiry |
| tmo_pin_o | output | 1 | Timeout indication pulse on expiry |

## Verification
Register writes take effect at the write edge. Reads are combinational, so a read-back made half a cycle after the write must already show the new value. The count changes at the edge exactly `TICK_CYCLES` edges after a load, and an output rises at the edge where the final tick is seen. Each output falls `PULSE_CYCLES` edges after it rose, and a reload without the reset output happens at that same falling edge. The bench records the index of the write edge from a free-running edge counter. It then samples on the falling clock edge just before and just after each due edge, so an off-by-one in either direction is visible.

// File: rtl/mkw_pkg.sv
package mkw_pkg;

  localparam int DATA_W = 8;
  localparam int ADDR_W = 2;

  localparam logic [ADDR_W-1:0] OFS_CTRL   = 2'd0;
  localparam logic [ADDR_W-1:0] OFS_PERIOD = 2'd1;
  localparam logic [ADDR_W-1:0] OFS_KICK   = 2'd2;
  localparam logic [ADDR_W-1:0] OFS_COUNT  = 2'd3;

  localparam int BIT_EN   = 0;
  localparam int BIT_LOCK = 2;
  localparam int BIT_RSEL = 6;
  localparam int BIT_PSEL = 7;

  localparam logic [DATA_W-1:0] KICK_MAGIC = 8'h6B;

  typedef struct packed {
    logic pin_sel;
    logic rst_sel;
    logic lock;
    logic en;
  } ctrl_t;

  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_COUNT = 2'd1,
    ST_FIRE  = 2'd2,
    ST_HALT  = 2'd3
  } cd_state_e;

  // Next control state for a write: lock is sticky, a locked enable cannot drop.
  function automatic ctrl_t ctrl_update(ctrl_t cur, logic [DATA_W-1:0] wd);
    ctrl_t n;
    n.en      = wd[BIT_EN] | (cur.lock & cur.en);
    n.lock    = cur.lock | wd[BIT_LOCK];
    n.rst_sel = wd[BIT_RSEL];
    n.pin_sel = wd[BIT_PSEL];
    return n;
  endfunction

  // Byte image of the control register for reads.
  function automatic logic [DATA_W-1:0] ctrl_image(ctrl_t c);
    logic [DATA_W-1:0] b;
    b           = '0;
    b[BIT_EN]   = c.en;
    b[BIT_LOCK] = c.lock;
    b[BIT_RSEL] = c.rst_sel;
    b[BIT_PSEL] = c.pin_sel;
    return b;
  endfunction

  // A tick at this count value ends the countdown.
  function automatic logic count_expires(logic [DATA_W-1:0] cnt);
    return cnt <= 8'd1;
  endfunction

  function automatic logic is_kick(logic wr, logic [ADDR_W-1:0] a, logic [DATA_W-1:0] d);
    return wr && (a == OFS_KICK) && (d == KICK_MAGIC);
  endfunction

endpackage

// File: rtl/mkw_tick_div.sv
module mkw_tick_div #(
  parameter int TICK_CYCLES = 50_000_000
) (
  input  logic clk,
  input  logic rst_n,
  input  logic run_i,
  input  logic restart_i,
  output logic tick_o
);
  localparam int PW = (TICK_CYCLES > 1) ? $clog2(TICK_CYCLES) : 1;
  localparam logic [PW-1:0] LAST = PW'(TICK_CYCLES - 1);

  logic [PW-1:0] pre_q;

  assign tick_o = run_i && !restart_i && (pre_q == LAST);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pre_q <= '0;
    end else if (!run_i || restart_i || tick_o) begin
      pre_q <= '0;
    end else begin
      pre_q <= pre_q + 1'b1;
    end
  end

  generate
    if (TICK_CYCLES > 1) begin : g_spacing
      AST_TICK_ISOLATED: assert property (@(posedge clk) disable iff (!rst_n)
        tick_o |=> !tick_o); // R4
    end
  endgenerate

endmodule

// File: rtl/mkw_regfile.sv
module mkw_regfile
  import mkw_pkg::*;
#(
  parameter logic [DATA_W-1:0] RESET_PERIOD = 8'd10
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_wr,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [DATA_W-1:0] bus_wdata,
  input  logic [DATA_W-1:0] count_i,
  output logic [DATA_W-1:0] bus_rdata,
  output ctrl_t             ctrl_o,
  output logic [DATA_W-1:0] period_o,
  output logic              start_o,
  output logic              kick_o
);
  ctrl_t             ctrl_q;
  logic [DATA_W-1:0] period_q;
  logic              wr_ctrl, wr_period;
  ctrl_t             ctrl_n;

  assign wr_ctrl   = bus_wr && (bus_addr == OFS_CTRL);
  assign wr_period = bus_wr && (bus_addr == OFS_PERIOD);
  assign ctrl_n    = ctrl_update(ctrl_q, bus_wdata);
  assign start_o   = wr_ctrl && ctrl_n.en && !ctrl_q.en;
  assign kick_o    = is_kick(bus_wr, bus_addr, bus_wdata);
  assign ctrl_o    = ctrl_q;
  assign period_o  = period_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ctrl_q   <= '0;
      period_q <= RESET_PERIOD;
    end else begin
      if (wr_ctrl)   ctrl_q   <= ctrl_n;
      if (wr_period) period_q <= bus_wdata;
    end
  end

  always_comb begin
    unique case (bus_addr)
      OFS_CTRL:   bus_rdata = ctrl_image(ctrl_q);
      OFS_PERIOD: bus_rdata = period_q;
      OFS_KICK:   bus_rdata = '0;
      default:    bus_rdata = count_i;
    endcase
  end

  AST_LOCK_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    ctrl_q.lock |=> ctrl_q.lock); // R10
  AST_LOCKED_EN_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    (ctrl_q.lock && ctrl_q.en) |=> ctrl_q.en); // R10
  AST_START_FROM_OFF: assert property (@(posedge clk) disable iff (!rst_n)
    start_o |=> ctrl_q.en); // R4

endmodule

// File: rtl/mkw_countdown.sv
module mkw_countdown
  import mkw_pkg::*;
#(
  parameter int PULSE_CYCLES = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  ctrl_t             ctrl_i,
  input  logic [DATA_W-1:0] period_i,
  input  logic              start_i,
  input  logic              kick_i,
  input  logic              tick_i,
  output logic [DATA_W-1:0] count_o,
  output logic              counting_o,
  output logic              reload_o,
  output logic              sys_rst_o,
  output logic              tmo_pin_o
);
  localparam int QW = (PULSE_CYCLES > 1) ? $clog2(PULSE_CYCLES) : 1;
  localparam logic [QW-1:0] PULSE_LAST = QW'(PULSE_CYCLES - 1);

  cd_state_e         st_q;
  logic [DATA_W-1:0] cnt_q;
  logic [QW-1:0]     pcnt_q;
  logic              out_rst_q, out_pin_q;
  logic              kick_take;
  logic              expire_now;

  assign kick_take  = kick_i && ctrl_i.en && (st_q != ST_FIRE);
  assign reload_o   = start_i || kick_take;
  assign expire_now = (st_q == ST_COUNT) && ctrl_i.en && tick_i && count_expires(cnt_q);
  assign counting_o = (st_q == ST_COUNT);
  assign count_o    = cnt_q;
  assign sys_rst_o  = out_rst_q;
  assign tmo_pin_o  = out_pin_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st_q      <= ST_IDLE;
      cnt_q     <= '0;
      pcnt_q    <= '0;
      out_rst_q <= 1'b0;
      out_pin_q <= 1'b0;
    end else if (start_i) begin
      st_q      <= ST_COUNT;
      cnt_q     <= period_i;
      out_rst_q <= 1'b0;
      out_pin_q <= 1'b0;
    end else if (!ctrl_i.en) begin
      st_q      <= ST_IDLE;
      out_rst_q <= 1'b0;
      out_pin_q <= 1'b0;
    end else if (kick_take) begin
      st_q      <= ST_COUNT;
      cnt_q     <= period_i;
      out_rst_q <= 1'b0;
      out_pin_q <= 1'b0;
    end else begin
      unique case (st_q)
        ST_COUNT: begin
          if (expire_now) begin
            st_q      <= ST_FIRE;
            cnt_q     <= '0;
            pcnt_q    <= PULSE_LAST;
            out_rst_q <= ctrl_i.rst_sel;
            out_pin_q <= ctrl_i.pin_sel;
          end else if (tick_i) begin
            cnt_q <= cnt_q - 1'b1;
          end
        end
        ST_FIRE: begin
          if (pcnt_q == '0) begin
            out_rst_q <= 1'b0;
            out_pin_q <= 1'b0;
            if (out_rst_q) begin
              st_q <= ST_HALT;
            end else begin
              st_q  <= ST_COUNT;
              cnt_q <= period_i;
            end
          end else begin
            pcnt_q <= pcnt_q - 1'b1;
          end
        end
        default: ;
      endcase
    end
  end

  AST_OUT_OFF_WHEN_DISABLED: assert property (@(posedge clk) disable iff (!rst_n)
    (!ctrl_i.en && !start_i) |=> (!sys_rst_o && !tmo_pin_o)); // R9
  AST_CNT_NEVER_RISES: assert property (@(posedge clk) disable iff (!rst_n)
    (ctrl_i.en && !reload_o && st_q != ST_FIRE) |=> (cnt_q <= $past(cnt_q))); // R4
  AST_EXPIRY_ON_TICK: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(sys_rst_o) || $rose(tmo_pin_o)) |-> $past(tick_i)); // R6
  AST_PULSE_NOT_CUT_BY_KICK: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == ST_FIRE && pcnt_q != '0 && ctrl_i.en) |=> (st_q == ST_FIRE)); // R11
  AST_HALT_HOLDS_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == ST_HALT && !reload_o && ctrl_i.en) |=> (cnt_q == '0)); // R7

endmodule

// File: rtl/magic_kick_watchdog.sv
module magic_kick_watchdog
  import mkw_pkg::*;
#(
  parameter int                TICK_CYCLES  = 50_000_000,
  parameter int                PULSE_CYCLES = 16,
  parameter logic [DATA_W-1:0] RESET_PERIOD = 8'd10
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_wr,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] bus_rdata,
  output logic              sys_rst_o,
  output logic              tmo_pin_o
);
  ctrl_t             ctrl;
  logic [DATA_W-1:0] period;
  logic [DATA_W-1:0] count;
  logic              start_ev, kick_ev, tick_ev, reload_ev, counting;

  mkw_regfile #(.RESET_PERIOD(RESET_PERIOD)) u_regs (
    .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .count_i(count), .bus_rdata(bus_rdata),
    .ctrl_o(ctrl), .period_o(period), .start_o(start_ev), .kick_o(kick_ev)
  );

  mkw_tick_div #(.TICK_CYCLES(TICK_CYCLES)) u_tick (
    .clk(clk), .rst_n(rst_n), .run_i(counting), .restart_i(reload_ev),
    .tick_o(tick_ev)
  );

  mkw_countdown #(.PULSE_CYCLES(PULSE_CYCLES)) u_cd (
    .clk(clk), .rst_n(rst_n), .ctrl_i(ctrl), .period_i(period),
    .start_i(start_ev), .kick_i(kick_ev), .tick_i(tick_ev),
    .count_o(count), .counting_o(counting), .reload_o(reload_ev),
    .sys_rst_o(sys_rst_o), .tmo_pin_o(tmo_pin_o)
  );

endmodule

// File: tb/tb_magic_kick_watchdog.sv
module tb_magic_kick_watchdog;
  localparam int TICK  = 10;
  localparam int PULSE = 4;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       bus_wr = 1'b0;
  logic [1:0] bus_addr = 2'd0;
  logic [7:0] bus_wdata = 8'h00;
  wire  [7:0] bus_rdata;
  wire        sys_rst_o, tmo_pin_o;

  int n_cmp = 0;
  int n_bad = 0;
  int cyc = 0;

  always #10 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  magic_kick_watchdog #(.TICK_CYCLES(TICK), .PULSE_CYCLES(PULSE), .RESET_PERIOD(8'd10)) dut (
    .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .sys_rst_o(sys_rst_o), .tmo_pin_o(tmo_pin_o)
  );

  // {is_read, addr, data, expected}
  localparam int NV = 23;
  localparam logic [18:0] VEC [NV] = '{
    {1'b1, 2'd0, 8'h00, 8'h00},  // R1 control
    {1'b1, 2'd1, 8'h00, 8'h0A},  // R1 period
    {1'b1, 2'd3, 8'h00, 8'h00},  // R1 count
    {1'b1, 2'd2, 8'h00, 8'h00},  // R2 kick reads 0
    {1'b0, 2'd1, 8'h05, 8'h00},
    {1'b1, 2'd1, 8'h00, 8'h05},  // R3
    {1'b0, 2'd1, 8'hFF, 8'h00},
    {1'b1, 2'd1, 8'h00, 8'hFF},  // R3
    {1'b0, 2'd0, 8'hC0, 8'h00},
    {1'b1, 2'd0, 8'h00, 8'hC0},  // R2 select bits
    {1'b0, 2'd0, 8'h3A, 8'h00},
    {1'b1, 2'd0, 8'h00, 8'h00},  // R2 unused bits read 0
    {1'b0, 2'd2, 8'h6B, 8'h00},
    {1'b1, 2'd3, 8'h00, 8'h00},  // R5 kick ignored while disabled
    {1'b0, 2'd0, 8'h04, 8'h00},
    {1'b1, 2'd0, 8'h00, 8'h04},  // R10 lock set
    {1'b0, 2'd0, 8'h00, 8'h00},
    {1'b1, 2'd0, 8'h00, 8'h04},  // R10 lock sticky
    {1'b0, 2'd0, 8'h01, 8'h00},
    {1'b1, 2'd0, 8'h00, 8'h05},  // R4 enable
    {1'b1, 2'd3, 8'h00, 8'hFF},  // R4 load from period
    {1'b0, 2'd0, 8'h00, 8'h00},
    {1'b1, 2'd0, 8'h00, 8'h05}   // R10 enable held
  };

  task automatic chk(input string tag, input int act, input int exp);
    n_cmp++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s actual=0x%0h expected=0x%0h (cycle %0d)", tag, act, exp, cyc);
    end
  endtask

  task automatic wr(input logic [1:0] a, input logic [7:0] d, output int edge_no);
    @(negedge clk);
    bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    edge_no = cyc;
    bus_wr = 1'b0;
  endtask

  task automatic rd(input logic [1:0] a, output logic [7:0] v);
    bus_addr = a;
    #1;
    v = bus_rdata;
  endtask

  task automatic wait_to(input int t);
    while (cyc < t) @(negedge clk);
  endtask

  task automatic do_reset();
    rst_n = 1'b0; bus_wr = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_cmp++; n_bad++;
    $display("FAIL watchdog: bench hung");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    int e, k, x;
    logic [7:0] v;
    do_reset();
    chk("R1 sys_rst low after reset", sys_rst_o, 0);
    chk("R1 tmo pin low after reset", tmo_pin_o, 0);

    for (int i = 0; i < NV; i++) begin
      if (VEC[i][18]) begin
        @(negedge clk);
        rd(VEC[i][17:16], v);
        chk($sformatf("table[%0d] R1/R2/R3/R4/R10 read", i), v, VEC[i][7:0]);
      end else begin
        wr(VEC[i][17:16], VEC[i][15:8], e);
      end
    end

    // Test A: reset output selected, kick during pulse, halt afterwards
    do_reset();
    wr(2'd1, 8'd3, e);
    wr(2'd0, 8'h41, e);
    wait_to(e + TICK - 1); rd(2'd3, v); chk("R4 count before first tick", v, 3);
    wait_to(e + TICK);     rd(2'd3, v); chk("R4 count after first tick", v, 2);
    wait_to(e + 3*TICK - 1); rd(2'd3, v);
    chk("R6 count before expiry", v, 1);
    chk("R6 no reset before expiry", sys_rst_o, 0);
    x = e + 3*TICK;
    wait_to(x);
    chk("R6 reset rises at expiry", sys_rst_o, 1);
    chk("R6 unselected pin stays low", tmo_pin_o, 0);
    rd(2'd3, v); chk("R6 count zero at expiry", v, 0);
    wr(2'd2, 8'h6B, k);
    chk("R11 pulse kept after kick", sys_rst_o, 1);
    rd(2'd3, v); chk("R11 count unchanged by kick in pulse", v, 0);
    wait_to(x + PULSE - 1); chk("R6 reset held full length", sys_rst_o, 1);
    wait_to(x + PULSE);     chk("R6 reset released", sys_rst_o, 0);
    wait_to(x + PULSE + 2*TICK); rd(2'd3, v);
    chk("R7 halted count stays zero", v, 0);
    chk("R7 no second pulse", sys_rst_o, 0);
    wr(2'd2, 8'h6B, k); rd(2'd3, v); chk("R7 kick leaves halt", v, 3);

    // Test B: bad and good kick, pin-only expiry with reload
    do_reset();
    wr(2'd1, 8'd4, e);
    wr(2'd0, 8'h81, e);
    wait_to(e + TICK); rd(2'd3, v); chk("R4 count 3", v, 3);
    wr(2'd2, 8'h6A, k); rd(2'd3, v); chk("R5 wrong kick value ignored", v, 3);
    wr(2'd2, 8'h6B, k); rd(2'd3, v); chk("R5 magic kick reloads", v, 4);
    wait_to(k + 4*TICK - 1); rd(2'd3, v);
    chk("R5 prescaler restarted by kick", v, 1);
    chk("R6 pin low before expiry", tmo_pin_o, 0);
    x = k + 4*TICK;
    wait_to(x);
    chk("R6 pin rises", tmo_pin_o, 1);
    chk("R6 unselected reset stays low", sys_rst_o, 0);
    wait_to(x + PULSE - 1); chk("R6 pin held", tmo_pin_o, 1);
    wait_to(x + PULSE);
    chk("R6 pin released", tmo_pin_o, 0);
    rd(2'd3, v); chk("R7 reload after pin-only pulse", v, 4);

    // Test C: period zero
    do_reset();
    wr(2'd1, 8'd0, e);
    wr(2'd0, 8'h41, e);
    wait_to(e + TICK - 1); chk("R8 no expiry before first tick", sys_rst_o, 0);
    wait_to(e + TICK);     chk("R8 expiry on first tick", sys_rst_o, 1);

    // Test D: disable while unlocked
    do_reset();
    wr(2'd1, 8'd2, e);
    wr(2'd0, 8'h01, e);
    wait_to(e + TICK); rd(2'd3, v); chk("R4 count 1", v, 1);
    wr(2'd0, 8'h00, k);
    rd(2'd0, v); chk("R9 enable cleared", v, 0);
    wait_to(k + 3*TICK); rd(2'd3, v);
    chk("R9 count held while disabled", v, 1);
    chk("R9 reset low while disabled", sys_rst_o, 0);
    chk("R9 pin low while disabled", tmo_pin_o, 0);
    wr(2'd2, 8'h6B, k); rd(2'd3, v); chk("R5 kick ignored while disabled", v, 1);
    wr(2'd0, 8'h01, k); rd(2'd3, v); chk("R4 re-enable reloads", v, 2);

    // Test E: lock
    do_reset();
    wr(2'd1, 8'd2, e);
    wr(2'd0, 8'h45, e);
    wr(2'd0, 8'h00, k);
    rd(2'd0, v); chk("R10 locked enable not cleared", v, 8'h05);
    wait_to(e + TICK); rd(2'd3, v); chk("R10 still counting when locked", v, 1);
    do_reset();
    rd(2'd0, v); chk("R10 reset clears lock", v, 0);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

endmodule